// File: doc/BRIEF.md
# Fourteen-Bit Square-Wave Timer

This block is a programmable down-counting timer driven by a slow external timer input. The input is brought into the system clock domain, and each rising edge of it counts as one input period. From a configured count length N and a two-bit output mode, the block drives a timer output. The output is either a square wave or a one-period low pulse, and it runs either once or repeatedly. Each completed cycle of N input periods is a terminal count, and each terminal count also raises a one-clock event that a status flag can capture.

Software stages the count length and the mode one byte at a time. A two-bit command then starts the timer, stops it at once, or stops it at the next terminal count. A start issued while the timer runs takes effect only at the end of the current cycle. Staged bytes never disturb a running count until a start command takes them. The staged configuration and the live position inside the current half-period can both be read back.

Top module: `sqwave_timer`

## Requirements
- R1: A low-byte write loads length bits 7:0. A high-byte write loads length bits 13:8 from data bits 5:0 and the mode from data bits 7:6, where bit 7 selects pulse output and bit 6 selects automatic reload. `cfg_rd` returns the mode in bits 15:14 and the staged length in bits 13:0.
- R2: In square-wave modes (mode bit 7 = 0), the output is high for the first ceil(N/2) input periods of each cycle and low for the remaining floor(N/2). An odd N therefore makes the high half one period longer.
- R3: In pulse modes (mode bit 7 = 1), the output is low for exactly the last input period of each cycle and high for all other periods.
- R4: With mode bit 6 = 1 the cycle repeats without pause. With mode bit 6 = 0 the timer stops after the first terminal count. While stopped, the output is high.
- R5: `tc_pulse` is high for exactly one clock at each terminal count and never while the timer is stopped.
- R6: A start command (code 11) is ignored when the staged length is below 2.
- R7: A start while stopped loads the staged mode and length and begins a new cycle at once. A start while running captures the staged values and applies them only at the next terminal count.
- R8: Writing the staged bytes while the timer runs leaves the running cycle unchanged.
- R9: Command 01 stops the timer at once, with no further terminal count. When the timer is already stopped, the command has no effect.
- R10: Command 10 lets the current cycle finish through its terminal count and then stops the timer.
- R11: Reset stops the timer and drives the output high, but keeps the staged length and mode. Counting restarts only after a start command.
- R12: `live_cnt` gives the number of input periods left in the current half-cycle, and `live_phase` is 1 during the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_in | input | 1 | Asynchronous timer input, counted on its rising edges |
| wr_lo | input | 1 | Write strobe for the low length byte |
| wr_hi | input | 1 | Write strobe for the high length/mode byte |
| wr_data | input | 8 | Byte written by the strobes |
| cmd_valid | input | 1 | Command strobe, one clock |
| cmd | input | 2 | Command: 00 none, 01 stop now, 10 stop at terminal count, 11 start |
| tmr_out | output | 1 | Registered timer output |
| tc_pulse | output | 1 | One-clock terminal-count event |
| running | output | 1 | Timer is counting |
| live_cnt | output | 14 | Input periods left in the current half-cycle |
| live_phase | output | 1 | 1 while in the high half-cycle |
| cfg_rd | output | 16 | Staged mode (15:14) and length (13:0) |

## Verification
The hardest situation to reach is a start command that lands while a cycle is in progress and that carries a different length and mode. In that case the old cycle has to finish unchanged before the new shape appears. The stimulus stages new bytes partway through a running cycle and issues the start a few input periods before the terminal count. It then compares every later input period against the old model up to the terminal count and against the new model afterwards. Random lengths and modes, together with the short lengths 1 and 2, cover the odd/even split and the smallest legal cycle.

// File: rtl/sqt_pkg.sv
package sqt_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_HALT    = 2'b01,
    CMD_HALT_TC = 2'b10,
    CMD_GO      = 2'b11
  } tcmd_e;

  // bit 1 = pulse output, bit 0 = automatic reload
  typedef struct packed {
    logic pulse;
    logic reload;
  } omode_t;
endpackage

// File: rtl/sqt_in_sync.sv
module sqt_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_tick
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      prev_q    <= 1'b0;
      rise_tick <= 1'b0;
    end else begin
      sync_q    <= {sync_q[STAGES-2:0], async_in};
      prev_q    <= sync_q[STAGES-1];
      rise_tick <= sync_q[STAGES-1] & ~prev_q;
    end
  end
endmodule

// File: rtl/sqt_cfg_regs.sv
module sqt_cfg_regs
  import sqt_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wr_data,
  output logic [CW-1:0] cfg_len,
  output omode_t        cfg_mode
);
  // Staged values are deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (wr_lo) cfg_len[7:0] <= wr_data;
    if (wr_hi) begin
      cfg_len[CW-1:8] <= wr_data[CW-9:0];
      cfg_mode        <= omode_t'(wr_data[7:6]);
    end
  end
endmodule

// File: rtl/sqt_engine.sv
module sqt_engine
  import sqt_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd,
  input  logic [CW-1:0] cfg_len,
  input  omode_t        cfg_mode,
  output logic          run_q,
  output logic          phase_q,
  output logic [CW-1:0] rem_q,
  output logic          pulse_q,
  output logic          tc_q
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] MIN_LEN = CW'(2);

  function automatic logic [CW-1:0] hi_half(input logic [CW-1:0] len);
    return (len >> 1) + {{(CW-1){1'b0}}, len[0]};
  endfunction

  function automatic logic [CW-1:0] lo_half(input logic [CW-1:0] len);
    return len >> 1;
  endfunction

  logic [CW-1:0] len_q, plen_q;
  omode_t        mode_q, pmode_q;
  logic          pend_q, stoptc_q;

  logic [CW-1:0] n_rem, n_len, n_plen;
  omode_t        n_mode, n_pmode;
  logic          n_run, n_phase, n_pend, n_stoptc, n_tc;
  tcmd_e         cmd_e;
  logic          len_ok;

  assign cmd_e  = tcmd_e'(cmd);
  assign len_ok = (cfg_len >= MIN_LEN);

  always_comb begin
    n_run    = run_q;
    n_phase  = phase_q;
    n_rem    = rem_q;
    n_len    = len_q;
    n_mode   = mode_q;
    n_pend   = pend_q;
    n_plen   = plen_q;
    n_pmode  = pmode_q;
    n_stoptc = stoptc_q;
    n_tc     = 1'b0;

    // counting on an input edge
    if (run_q && tick) begin
      if (rem_q > ONE) begin
        n_rem = rem_q - ONE;
      end else if (phase_q) begin
        n_phase = 1'b0;
        n_rem   = lo_half(len_q);
      end else begin
        n_tc = 1'b1;
        if (pend_q) begin
          n_len   = plen_q;
          n_mode  = pmode_q;
          n_phase = 1'b1;
          n_rem   = hi_half(plen_q);
          n_pend  = 1'b0;
        end else if (stoptc_q || !mode_q.reload) begin
          n_run    = 1'b0;
          n_stoptc = 1'b0;
        end else begin
          n_phase = 1'b1;
          n_rem   = hi_half(len_q);
        end
      end
    end

    // commands act on the state left by the edge above
    if (cmd_valid) begin
      case (cmd_e)
        CMD_GO: begin
          if (len_ok) begin
            n_stoptc = 1'b0;
            if (!n_run) begin
              n_run   = 1'b1;
              n_len   = cfg_len;
              n_mode  = cfg_mode;
              n_phase = 1'b1;
              n_rem   = hi_half(cfg_len);
              n_pend  = 1'b0;
            end else begin
              n_pend  = 1'b1;
              n_plen  = cfg_len;
              n_pmode = cfg_mode;
            end
          end
        end
        CMD_HALT: begin
          n_run    = 1'b0;
          n_pend   = 1'b0;
          n_stoptc = 1'b0;
        end
        CMD_HALT_TC: begin
          if (n_run) begin
            n_stoptc = 1'b1;
            n_pend   = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      phase_q  <= 1'b1;
      rem_q    <= '0;
      len_q    <= '0;
      mode_q   <= '0;
      pend_q   <= 1'b0;
      plen_q   <= '0;
      pmode_q  <= '0;
      stoptc_q <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      run_q    <= n_run;
      phase_q  <= n_phase;
      rem_q    <= n_rem;
      len_q    <= n_len;
      mode_q   <= n_mode;
      pend_q   <= n_pend;
      plen_q   <= n_plen;
      pmode_q  <= n_pmode;
      stoptc_q <= n_stoptc;
      tc_q     <= n_tc;
    end
  end

  assign pulse_q = mode_q.pulse;
endmodule

// File: rtl/sqt_wave.sv
module sqt_wave #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          phase,
  input  logic [CW-1:0] rem,
  input  logic          pulse_mode,
  output logic          wave_q
);
  logic wave_d;

  always_comb begin
    if (!run)            wave_d = 1'b1;
    else if (!pulse_mode) wave_d = phase;
    else                 wave_d = ~(~phase & (rem == CW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b1;
    else     wave_q <= wave_d;
  end
endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer
  import sqt_pkg::*;
#(
  parameter int CW          = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmr_in,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wr_data,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd,
  output logic          tmr_out,
  output logic          tc_pulse,
  output logic          running,
  output logic [CW-1:0] live_cnt,
  output logic          live_phase,
  output logic [15:0]   cfg_rd
);
  logic          tick;
  logic [CW-1:0] cfg_len;
  omode_t        cfg_mode;
  logic          pulse_act;

  sqt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(tmr_in), .rise_tick(tick)
  );

  sqt_cfg_regs #(.CW(CW)) u_cfg (
    .clk(clk), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .cfg_len(cfg_len), .cfg_mode(cfg_mode)
  );

  sqt_engine #(.CW(CW)) u_eng (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .cmd(cmd),
    .cfg_len(cfg_len), .cfg_mode(cfg_mode),
    .run_q(running), .phase_q(live_phase), .rem_q(live_cnt),
    .pulse_q(pulse_act), .tc_q(tc_pulse)
  );

  sqt_wave #(.CW(CW)) u_wave (
    .clk(clk), .rst(rst), .run(running), .phase(live_phase),
    .rem(live_cnt), .pulse_mode(pulse_act), .wave_q(tmr_out)
  );

  assign cfg_rd = {cfg_mode, 14'(cfg_len)};
endmodule

// File: rtl/sqt_checker.sv
module sqt_checker #(
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [1:0]    cmd,
  input logic          tmr_out,
  input logic          tc_pulse,
  input logic          running,
  input logic [CW-1:0] live_cnt,
  input logic [15:0]   cfg_rd
);
  assert_tc_single_R5: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  assert_tc_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> $past(running));

  assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
    !running |=> tmr_out);

  assert_short_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == 2'b11 && !running && cfg_rd[CW-1:0] < CW'(2)) |=> !running);

  assert_halt_now_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == 2'b01) |=> !running);

  assert_live_nonzero_R12: assert property (@(posedge clk) disable iff (rst)
    running |-> (live_cnt != '0));
endmodule

bind sqwave_timer sqt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
  .tmr_out(tmr_out), .tc_pulse(tc_pulse), .running(running),
  .live_cnt(live_cnt), .cfg_rd(cfg_rd)
);

// File: tb/test_sqwave_timer.sv
`timescale 1ns/1ps
module test_sqwave_timer;
  localparam int CW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tmr_in = 1'b0;
  logic          wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic          tmr_out, tc_pulse, running, live_phase;
  logic [CW-1:0] live_cnt;
  logic [15:0]   cfg_rd;

  int checks = 0;
  int failures = 0;
  int tc_cnt = 0;
  int base;

  sqwave_timer #(.CW(CW)) i_sqwave_timer (
    .clk(clk), .rst(rst), .tmr_in(tmr_in), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd(cmd), .tmr_out(tmr_out),
    .tc_pulse(tc_pulse), .running(running), .live_cnt(live_cnt),
    .live_phase(live_phase), .cfg_rd(cfg_rd)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (!rst && tc_pulse) tc_cnt <= tc_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: bit1 pulse, bit0 reload; k counts input periods from 1
  function automatic int exp_out(input int n, input int mode, input int k);
    int j;
    if (mode[0] == 1'b0 && k > n) return 1;
    j = (k - 1) % n;
    if (mode[1] == 1'b0) return (j < (n + 1) / 2) ? 1 : 0;
    return (j == n - 1) ? 0 : 1;
  endfunction

  task automatic write_cfg(input int len, input int mode);
    @(negedge clk); wr_lo = 1'b1; wr_data = len[7:0];
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wr_data = {mode[1:0], len[13:8]};
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0; cmd = 2'b00;
    repeat (2) @(negedge clk);
  endtask

  task automatic tin_period(output int s);
    repeat (5) @(negedge clk);
    s = int'(tmr_out);
    tmr_in = 1'b1;
    repeat (5) @(negedge clk);
    tmr_in = 1'b0;
  endtask

  task automatic run_check(input int n, input int mode, input int k0,
                           input int cnt, input string req);
    int s;
    for (int i = 0; i < cnt; i++) begin
      tin_period(s);
      chk(req, s, exp_out(n, mode, k0 + i));
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int s, n, m;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset out", int'(tmr_out), 1);
    chk("R11 reset running", int'(running), 0);
    chk("R5 reset tc", int'(tc_pulse), 0);

    // R1 staged field layout
    write_cfg(14'h2A5B & 14'h3FFF, 2'b10);
    chk("R1 cfg readback", int'(cfg_rd), 32'h8000 | (14'h2A5B & 14'h3FFF));

    // R2 odd length, continuous square; R12 live readback
    write_cfg(9, 2'b01);
    base = tc_cnt;
    issue(2'b11);
    chk("R7 start while stopped", int'(running), 1);
    run_check(9, 1, 1, 2, "R2 odd square");
    settle();
    chk("R12 live_cnt", int'(live_cnt), 3);
    chk("R12 live_phase", int'(live_phase), 1);
    run_check(9, 1, 3, 16, "R2 odd square");
    settle();
    chk("R5 tc count odd", tc_cnt - base, 2);
    issue(2'b01);

    // R4 single square even
    write_cfg(6, 2'b00);
    base = tc_cnt;
    issue(2'b11);
    run_check(6, 0, 1, 9, "R4 single square");
    chk("R4 single stops", int'(running), 0);
    chk("R5 single tc", tc_cnt - base, 1);

    // R3 continuous pulses and single pulse
    write_cfg(4, 2'b11);
    base = tc_cnt;
    issue(2'b11);
    run_check(4, 3, 1, 12, "R3 cont pulse");
    settle();
    chk("R5 pulse tc", tc_cnt - base, 3);
    issue(2'b01);
    write_cfg(5, 2'b10);
    issue(2'b11);
    run_check(5, 2, 1, 8, "R3 single pulse");
    chk("R4 single pulse stops", int'(running), 0);

    // minimum length 2
    write_cfg(2, 2'b01);
    issue(2'b11);
    run_check(2, 1, 1, 6, "R2 min length");
    issue(2'b01);

    // R6 short lengths
    for (int L = 0; L < 2; L++) begin
      write_cfg(L, 2'b01);
      base = tc_cnt;
      issue(2'b11);
      chk("R6 short start ignored", int'(running), 0);
      tin_period(s);
      tin_period(s);
      chk("R6 short out idle", s, 1);
      chk("R6 short no tc", tc_cnt - base, 0);
    end

    // R8 staged writes while running
    write_cfg(6, 2'b01);
    issue(2'b11);
    run_check(6, 1, 1, 3, "R8 before write");
    write_cfg(2, 2'b10);
    chk("R1 cfg staged while running", int'(cfg_rd), 32'h8002);
    run_check(6, 1, 4, 9, "R8 write has no effect");
    issue(2'b01);

    // R7 deferred start
    write_cfg(6, 2'b01);
    base = tc_cnt;
    issue(2'b11);
    run_check(6, 1, 1, 2, "R7 old cycle");
    write_cfg(4, 2'b11);
    issue(2'b11);
    run_check(6, 1, 3, 4, "R7 old cycle completes");
    run_check(4, 3, 1, 8, "R7 new cycle after tc");
    settle();
    chk("R7 tc count", tc_cnt - base, 3);
    issue(2'b01);

    // R9 stop now
    write_cfg(8, 2'b01);
    base = tc_cnt;
    issue(2'b11);
    run_check(8, 1, 1, 2, "R9 before halt");
    issue(2'b01);
    chk("R9 halted", int'(running), 0);
    tin_period(s); chk("R9 out high", s, 1);
    for (int i = 0; i < 10; i++) tin_period(s);
    chk("R9 no tc", tc_cnt - base, 0);
    issue(2'b01);
    chk("R9 nop when stopped", int'(running), 0);

    // R10 stop at terminal count
    write_cfg(5, 2'b11);
    base = tc_cnt;
    issue(2'b11);
    run_check(5, 3, 1, 2, "R10 before request");
    issue(2'b10);
    run_check(5, 3, 3, 3, "R10 cycle finishes");
    chk("R10 stopped", int'(running), 0);
    run_check(5, 2, 6, 3, "R10 idle");
    chk("R10 tc once", tc_cnt - base, 1);

    // R11 reset mid-run keeps staged values
    write_cfg(7, 2'b01);
    issue(2'b11);
    run_check(7, 1, 1, 3, "R11 before reset");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R11 stopped", int'(running), 0);
    chk("R11 out high", int'(tmr_out), 1);
    chk("R11 cfg kept", int'(cfg_rd), 32'h4007);
    tin_period(s); chk("R11 no count", s, 1);
    issue(2'b11);
    run_check(7, 1, 1, 7, "R11 restart");
    issue(2'b01);

    // random lengths and modes
    for (int it = 0; it < 10; it++) begin
      n = 2 + int'($urandom % 39);
      m = int'($urandom % 4);
      write_cfg(n, m);
      base = tc_cnt;
      issue(2'b11);
      run_check(n, m, 1, 2 * n, (m[1] ? "R3 random" : "R2 random"));
      settle();
      chk("R4 random tc", tc_cnt - base, m[0] ? 2 : 1);
      issue(2'b01);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule